// File: doc/BRIEF.md
# Top-Level Non-Maskable Interrupt Controller

This block converts an asynchronous external interrupt pin into a top-level interrupt request for a processor core. The pin is resynchronized into the core clock domain, and each low-to-high transition becomes a single-cycle event. When software has enabled event capture, that event latches a pending flag. The request to the core is the pending flag qualified either by a sticky non-maskable control bit or by the pairing of a local enable with the core's global interrupt enable.

Software reaches the control and status bits through a small word-addressed register port. The core clears the pending flag with an acknowledge strobe once it takes the interrupt. A pin that stays high after service does not raise a second request. Only a new rising transition does. Once the non-maskable bit is set, software cannot clear it. Only reset removes it.

Top module: `nmi_toplevel_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every control bit and the pending flag read 0, and `irq_req` is 0.
- R2: With capture enabled (control bit 0 = 1), a rising transition on `nmi_pin` makes the pending flag (status register, address 1, bit 0) read 1 exactly SYNC_STAGES+1 clock edges after the pin change. Before that edge it reads 0.
- R3: A rising transition that the synchronizer detects while capture is disabled is ignored. The pending flag stays 0, including after capture is enabled later.
- R4: `irq_req` is 1 exactly when the pending flag is 1 and either the non-maskable bit (control bit 2) is 1, or both the local enable (control bit 1) and `glob_irq_en` are 1.
- R5: Writing 1 to the non-maskable bit sets it. Later writes of 0 leave it set until reset.
- R6: A pin that stays high produces no further pending event after the flag is cleared.
- R7: `cpu_ack` high at a clock edge clears the pending flag at that edge.
- R8: When a detected, enabled edge coincides with an acknowledge or a software clear, the pending flag ends up set.
- R9: Writing 0 to status bit 0 clears the pending flag. Writing 1 leaves it unchanged.
- R10: The control register sits at address 0: bit 0 capture enable, bit 1 local enable, bit 2 non-maskable. The status register sits at address 1: bit 0 pending. Unused bits and other addresses read 0. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Asynchronous external interrupt pin |
| glob_irq_en | input | 1 | Global interrupt enable from the core |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| cpu_ack | input | 1 | Core acknowledge, clears pending |
| irq_req | output | 1 | Top-level interrupt request to the core |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default of 2. This checks that the capture latency follows the parameter and does not rely on a fixed two-stage chain. ADDR_W stays at 2, so random traffic also reads the two unused addresses and checks that they return 0. DATA_W stays at 8, so writes with the upper bits set confirm that those bits are not stored.

// File: rtl/nmi_pkg.sv
// Package: shared register map and control type for the top-level NMI controller.
// Assumes register addresses fit in any ADDR_W >= 1.
package nmi_pkg;

    // Register addresses
    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_STAT = 1;

    // Control register bit positions
    localparam int unsigned BIT_EDGE_EN = 0;
    localparam int unsigned BIT_IRQ_EN  = 1;
    localparam int unsigned BIT_NM_LOCK = 2;

    // Status register bit position
    localparam int unsigned BIT_PEND = 0;

    // Minimum data width that holds every control bit
    localparam int unsigned MIN_DATA_W = 3;

    typedef struct packed {
        logic nm_lock;
        logic irq_en;
        logic edge_en;
    } nmi_ctrl_t;

endpackage

// File: rtl/nmi_edge_sync.sv
// Module: nmi_edge_sync
// Resynchronizes the asynchronous pin through STAGES flops. Emits a one-cycle
// pulse when the synchronized level goes from 0 to 1.
// Assumes STAGES >= 1. A level held high gives exactly one pulse.
module nmi_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              level;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_async;
            end
        end else begin : g_chain
            // Shift the pin through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign level = sync_q[STAGES-1];

    // Hold the previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= level;
    end

    // Rising-edge pulse from the synchronized level
    always_comb begin
        rise = level & ~last_q;
    end

    // A rise pulse never lasts two cycles, so a held level cannot re-trigger
    assert_single_pulse_R6: assert property (
        @(posedge clk) disable iff (!rst_n) rise |=> !rise
    );

endmodule

// File: rtl/nmi_ctrl_regs.sv
// Module: nmi_ctrl_regs
// Holds the control bits. The non-maskable bit is write-1-to-set. Only reset
// clears it.
// Assumes DATA_W >= 3 and that writes are single-cycle strobes.
module nmi_ctrl_regs
    import nmi_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output nmi_ctrl_t         ctrl
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(ADDR_CTRL);

    logic ctrl_hit;

    // Decode a write to the control register
    always_comb begin
        ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);
    end

    // Update the enables. The lock bit only accumulates ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_hit) begin
            ctrl.edge_en <= wr_data[BIT_EDGE_EN];
            ctrl.irq_en  <= wr_data[BIT_IRQ_EN];
            ctrl.nm_lock <= ctrl.nm_lock | wr_data[BIT_NM_LOCK];
        end
    end

    // Once set, the non-maskable bit stays set until reset
    assert_lock_sticky_R5: assert property (
        @(posedge clk) disable iff (!rst_n) ctrl.nm_lock |=> ctrl.nm_lock
    );

endmodule

// File: rtl/nmi_pend_flag.sv
// Module: nmi_pend_flag
// Pending flag: an enabled rise sets it. An acknowledge or a software clear
// resets it. A set in the same cycle overrides a clear.
// Assumes rise is a single-cycle pulse in the clk domain.
module nmi_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic edge_en,
    input  logic ack,
    input  logic sw_clr,
    output logic pending
);

    logic set_ev;
    logic clr_ev;

    // Qualify set and clear events
    always_comb begin
        set_ev = rise & edge_en;
        clr_ev = ack | sw_clr;
    end

    // Pending flag state, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= 1'b0;
        else if (set_ev) pending <= 1'b1;
        else if (clr_ev) pending <= 1'b0;
    end

    assert_set_wins_R8: assert property (
        @(posedge clk) disable iff (!rst_n) (rise && edge_en) |=> pending
    );

    assert_ack_clears_R7: assert property (
        @(posedge clk) disable iff (!rst_n) (ack && !(rise && edge_en)) |=> !pending
    );

    assert_no_capture_disabled_R3: assert property (
        @(posedge clk) disable iff (!rst_n) (!pending && !edge_en) |=> !pending
    );

endmodule

// File: rtl/nmi_toplevel_ctrl.sv
// Module: nmi_toplevel_ctrl
// Top-level NMI controller. Ties together the synchronizer, control register,
// pending flag, read mux and request qualification.
// Assumes DATA_W >= 3. glob_irq_en comes from the core clock domain.
module nmi_toplevel_ctrl
    import nmi_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic              glob_irq_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cpu_ack,
    output logic              irq_req
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(ADDR_STAT);

    nmi_ctrl_t ctrl;
    logic      rise;
    logic      pending;
    logic      sw_clr;

    // Reject data widths too narrow for the control bits
    initial begin
        assert_width_ok_R10: assert (DATA_W >= MIN_DATA_W);
    end

    nmi_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (nmi_pin),
        .rise      (rise)
    );

    nmi_ctrl_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .ctrl    (ctrl)
    );

    // Software clear: write 0 to the pending bit
    always_comb begin
        sw_clr = reg_wr && (reg_addr == STAT_ADDR) && !reg_wdata[BIT_PEND];
    end

    nmi_pend_flag u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise),
        .edge_en (ctrl.edge_en),
        .ack     (cpu_ack),
        .sw_clr  (sw_clr),
        .pending (pending)
    );

    // Read mux over the two registers
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata[BIT_EDGE_EN] = ctrl.edge_en;
            reg_rdata[BIT_IRQ_EN]  = ctrl.irq_en;
            reg_rdata[BIT_NM_LOCK] = ctrl.nm_lock;
        end else if (reg_addr == STAT_ADDR) begin
            reg_rdata[BIT_PEND] = pending;
        end
    end

    // Qualify the request: non-maskable, or locally and globally enabled
    always_comb begin
        irq_req = pending & (ctrl.nm_lock | (ctrl.irq_en & glob_irq_en));
    end

    // With the lock set, a pending flag always reaches the core
    assert_lock_forces_req_R4: assert property (
        @(posedge clk) disable iff (!rst_n) (pending && ctrl.nm_lock) |-> irq_req
    );

endmodule

// File: tb/tb_nmi_toplevel_ctrl.sv
module tb_nmi_toplevel_ctrl;

    localparam int STAGES = 3;
    localparam int AW     = 2;
    localparam int DW     = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nmi_pin = 1'b0;
    logic          glob_irq_en = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          cpu_ack = 1'b0;
    logic          irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state built from the requirements
    logic [STAGES-1:0] m_sh;
    logic m_prev, m_en, m_ie, m_lk, m_pd;

    always #5 clk = ~clk;

    nmi_toplevel_ctrl #(
        .SYNC_STAGES (STAGES),
        .ADDR_W      (AW),
        .DATA_W      (DW)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_pin     (nmi_pin),
        .glob_irq_en (glob_irq_en),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cpu_ack     (cpu_ack),
        .irq_req     (irq_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_read(input logic [AW-1:0] a);
        if (a == 0) return {m_lk, m_ie, m_en};
        if (a == 1) return {7'b0, m_pd};
        return 0;
    endfunction

    function automatic int exp_irq(input logic g);
        return int'(m_pd & (m_lk | (m_ie & g)));
    endfunction

    task automatic model_reset();
        m_sh = '0; m_prev = 0; m_en = 0; m_ie = 0; m_lk = 0; m_pd = 0;
    endtask

    // One cycle: drive at negedge, update model at posedge, compare at negedge
    task automatic step(input logic pin, input logic g, input logic wr,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic ack, input string tag);
        logic rise_m, clr_m;
        nmi_pin = pin; glob_irq_en = g; reg_wr = wr; reg_addr = a;
        reg_wdata = wd; cpu_ack = ack;
        @(posedge clk);
        rise_m = m_sh[STAGES-1] & ~m_prev;
        clr_m  = ack | (wr && a == 1 && !wd[0]);
        if (rise_m && m_en) m_pd = 1'b1;
        else if (clr_m)     m_pd = 1'b0;
        if (wr && a == 0) begin
            m_en = wd[0]; m_ie = wd[1]; m_lk = m_lk | wd[2];
        end
        m_prev = m_sh[STAGES-1];
        m_sh   = {m_sh[STAGES-2:0], pin};
        @(negedge clk);
        reg_wr = 1'b0; cpu_ack = 1'b0;
        chk(tag, int'(reg_rdata), exp_read(a));
        chk(tag, int'(irq_req), exp_irq(g));
    endtask

    task automatic idle(input int n, input logic pin, input logic [AW-1:0] a, input string tag);
        for (int i = 0; i < n; i++) step(pin, glob_irq_en, 0, a, 0, 0, tag);
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(0, v); chk("R1 ctrl", int'(v), 0);
        peek(1, v); chk("R1 status", int'(v), 0);
        chk("R1 irq", int'(irq_req), 0);

        // R10: register map, upper bits not stored
        step(0, 0, 1, 0, 8'hFB, 0, "R10 write ctrl");
        peek(0, v); chk("R10 ctrl readback", int'(v), 3);
        peek(2, v); chk("R10 unused addr", int'(v), 0);

        // R2: capture latency is STAGES+1 edges
        for (int i = 1; i <= STAGES + 1; i++) begin
            step(1, 0, 0, 1, 0, 0, "R2 latency");
            chk("R2 pending timing", int'(reg_rdata[0]), (i >= STAGES + 1) ? 1 : 0);
        end

        // R4: request qualification
        step(1, 0, 0, 1, 0, 0, "R4 gie off");
        chk("R4 gie off", int'(irq_req), 0);
        step(1, 1, 0, 1, 0, 0, "R4 both on");
        chk("R4 both on", int'(irq_req), 1);
        step(1, 1, 1, 0, 8'h01, 0, "R4 local off");
        chk("R4 local off", int'(irq_req), 0);
        step(1, 1, 1, 0, 8'h03, 0, "R4 restore");

        // R9: write 1 keeps, write 0 clears
        step(1, 1, 1, 1, 8'h01, 0, "R9 write one");
        peek(1, v); chk("R9 write one", int'(v), 1);
        step(1, 1, 1, 1, 8'h00, 0, "R9 write zero");
        peek(1, v); chk("R9 write zero", int'(v), 0);

        // R6: held high gives nothing more
        idle(10, 1, 1, "R6 held");
        peek(1, v); chk("R6 held high", int'(v), 0);
        chk("R6 irq", int'(irq_req), 0);

        // R7: ack clears on the next edge
        idle(STAGES + 2, 0, 1, "R7 low");
        idle(STAGES + 1, 1, 1, "R7 rise");
        peek(1, v); chk("R7 set before ack", int'(v), 1);
        step(1, 1, 0, 1, 0, 1, "R7 ack");
        chk("R7 ack cleared", int'(reg_rdata[0]), 0);

        // R8: new edge coincides with ack, set wins
        idle(2, 1, 1, "R8 prep");
        idle(STAGES + 2, 0, 1, "R8 low");
        idle(STAGES + 1, 1, 1, "R8 first");
        idle(STAGES + 2, 0, 1, "R8 low2");
        idle(STAGES, 1, 1, "R8 rise");
        step(1, 1, 0, 1, 0, 1, "R8 collide ack");
        chk("R8 set wins ack", int'(reg_rdata[0]), 1);
        idle(STAGES + 2, 0, 1, "R8 low3");
        idle(STAGES, 1, 1, "R8 rise2");
        step(1, 1, 1, 1, 8'h00, 0, "R8 collide swclr");
        chk("R8 set wins sw clear", int'(reg_rdata[0]), 1);
        step(1, 1, 0, 1, 0, 1, "R8 cleanup");

        // R3: capture disabled ignores edge, later enable does not resurrect
        step(0, 1, 1, 0, 8'h02, 0, "R3 disable");
        idle(STAGES + 2, 0, 1, "R3 low");
        idle(STAGES + 3, 1, 1, "R3 rise");
        peek(1, v); chk("R3 ignored", int'(v), 0);
        step(1, 1, 1, 0, 8'h03, 0, "R3 enable");
        idle(4, 1, 1, "R3 after enable");
        peek(1, v); chk("R3 stays clear", int'(v), 0);

        // Random traffic, lock bit kept clear
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic p, w, k;
            a = AW'($urandom_range(0, 3));
            d = DW'($urandom);
            if (a == 0) d[2] = 1'b0;
            w = ($urandom_range(0, 7) == 0);
            k = ($urandom_range(0, 7) == 0);
            p = ($urandom_range(0, 3) == 0) ? ~nmi_pin : nmi_pin;
            step(p, 1'($urandom_range(0, 1)), w, a, d, k, "R2/R4/R7/R9 random");
        end

        // R5: lock sticky, forces request
        step(0, 0, 1, 0, 8'h05, 0, "R5 set lock");
        step(0, 0, 1, 0, 8'h01, 0, "R5 write zero");
        peek(0, v); chk("R5 lock kept", int'(v[2]), 1);
        idle(STAGES + 1, 1, 1, "R5 rise");
        chk("R5 nonmaskable irq", int'(irq_req), 1);

        // R1: reset clears lock
        rst_n = 1'b0;
        @(posedge clk); model_reset(); @(negedge clk);
        rst_n = 1'b1;
        peek(0, v); chk("R1 lock reset", int'(v), 0);
        peek(1, v); chk("R1 pending reset", int'(v), 0);
        chk("R1 irq reset", int'(irq_req), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule